// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital supervisor inside a LIN physical-layer transceiver that carries its own voltage regulator. It decides which operating mode the transceiver is in (unpowered, fail-safe, normal, silent or sleep). It then drives the enables for the bus transmitter, the receive path, the regulator and the full slave termination. It also drives a reset output for the host and an override that pulls the host's RXD line low. Analog results such as the supply-undervoltage flag, the regulator-undervoltage flag and a qualified bus wake-up pulse arrive as synchronous single-bit flags.

The host moves the block into normal mode by holding EN high. To leave normal mode, the host lowers EN. A counted selection window then opens, and the level of TXD at the end of that window chooses silent mode (TXD high) or sleep mode (TXD low). This lets the host release TXD shortly after EN without the bus seeing a dominant pulse. A bus wake-up from silent or sleep mode always passes through fail-safe mode first. In fail-safe mode the RXD override tells the host that a wake-up happened.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While and directly after reset the mode output reads fail-safe. Mode codes are 0 unpowered, 1 fail-safe, 2 normal, 3 silent and 4 sleep. In this state the regulator enable is high, the transmitter and receive enables are low, and the reset output is low.
- R2: A low supply flag sends the block to unpowered mode from any mode. There, the regulator, transmitter, receive and termination enables are low and the reset output is low. When the flag returns high the block enters fail-safe mode.
- R3: The reset output stays low, and fail-safe mode cannot be left, for RST_CYCLES clocks in three cases: after fail-safe is entered from unpowered or sleep mode, after reset, and after a regulator undervoltage clears. Once that count has elapsed, the reset output follows the regulator being on and free of undervoltage.
- R4: In fail-safe mode, a high EN (once the R3 delay is over and with no regulator undervoltage) moves the block to normal mode. Normal mode enables the transmitter, the receive path and the termination.
- R5: In normal mode, a falling EN opens a selection window of WIN_CYCLES clocks, shown on the window output. The transmitter enable is low while the window is open. EN rising again inside the window cancels it, and the block stays in normal mode.
- R6: At the end of the window, a high TXD selects silent mode: regulator on, termination, transmitter and receive path off, RXD not forced. A low TXD selects sleep mode: regulator off, RXD forced low, reset output low, termination off.
- R7: A wake-up pulse in silent or sleep mode moves the block to fail-safe mode with RXD forced low, and RXD stays forced low until normal mode is entered. A wake-up pulse in fail-safe or normal mode has no effect.
- R8: A regulator undervoltage in normal or silent mode returns the block to fail-safe mode and pulls the reset output low. In sleep mode, where the regulator is off, the flag is ignored.
- R9: A high EN in silent mode returns the block straight to normal mode. In sleep mode, a high EN moves it to fail-safe mode, and it reaches normal mode after the R3 delay if EN is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Battery supply above its undervoltage threshold |
| vreg_uv | input | 1 | Regulator output below its undervoltage threshold |
| en_pin | input | 1 | Asynchronous enable pin from the host |
| txd_pin | input | 1 | Asynchronous transmit-data pin from the host |
| wake_pulse | input | 1 | One-clock qualified remote wake-up request |
| mode_o | output | 3 | Current mode code (see R1) |
| tx_en | output | 1 | Bus transmitter enable |
| rx_en | output | 1 | LIN-to-RXD receive path enable |
| vreg_en | output | 1 | Regulator enable |
| term_en | output | 1 | Full slave termination enable |
| rxd_low | output | 1 | Forces the host RXD line low |
| nres | output | 1 | Reset output to the host, low active |
| sel_win | output | 1 | Mode-selection window open |

## Verification
The main sweep starts from each of fail-safe, normal, silent and sleep mode. From each it applies all sixteen combinations of EN, TXD, wake-up and regulator undervoltage. An arithmetic model predicts the mode and every enable once the combination has settled. Mixing wake-up with EN separates the two paths out of sleep mode. Mixing undervoltage with wake-up in silent mode shows which flag takes priority. Directed cases place the TXD fall inside and beyond the selection window, let EN return inside the window, and remove the supply from silent mode, which probes the window length and the power-up reset delay.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [2:0] {
    M_UNPOW  = 3'd0,
    M_FSAFE  = 3'd1,
    M_NORMAL = 3'd2,
    M_SILENT = 3'd3,
    M_SLEEP  = 3'd4
  } mode_t;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lin_rst_timer.sv
module lin_rst_timer #(
  parameter int RST_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || reload) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lin_sel_window.sv
module lin_sel_window #(
  parameter int WIN_CYCLES = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic abort,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || abort) cnt_q <= '0;
    else if (arm) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign done   = (cnt_q == LAST) && !abort;
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  supply_ok,
  input  logic  vreg_uv,
  input  logic  en_s,
  input  logic  txd_s,
  input  logic  wake,
  input  logic  hold,
  input  logic  win_done,
  output mode_t mode_q,
  output logic  wflag_q
);
  mode_t mode_d;
  logic  wflag_d;

  always_comb begin
    mode_d  = mode_q;
    wflag_d = wflag_q;
    if (!supply_ok) begin
      mode_d = M_UNPOW;
    end else begin
      unique case (mode_q)
        M_UNPOW:  mode_d = M_FSAFE;
        M_FSAFE:  if (en_s && !hold && !vreg_uv) mode_d = M_NORMAL;
        M_NORMAL: begin
          if (vreg_uv) mode_d = M_FSAFE;
          else if (win_done) mode_d = txd_s ? M_SILENT : M_SLEEP;
        end
        M_SILENT: begin
          if (vreg_uv) mode_d = M_FSAFE;
          else if (wake) begin
            mode_d  = M_FSAFE;
            wflag_d = 1'b1;
          end else if (en_s) mode_d = M_NORMAL;
        end
        M_SLEEP: begin
          if (wake) begin
            mode_d  = M_FSAFE;
            wflag_d = 1'b1;
          end else if (en_s) mode_d = M_FSAFE;
        end
        default: mode_d = M_FSAFE;
      endcase
    end
    if (mode_d == M_NORMAL || mode_d == M_UNPOW) wflag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_FSAFE;
      wflag_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      wflag_q <= wflag_d;
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int RST_CYCLES = 200000,
  parameter int WIN_CYCLES = 160,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic       vreg_uv,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       wake_pulse,
  output logic [2:0] mode_o,
  output logic       tx_en,
  output logic       rx_en,
  output logic       vreg_en,
  output logic       term_en,
  output logic       rxd_low,
  output logic       nres,
  output logic       sel_win
);
  logic [1:0] pins_s;
  logic       en_s, txd_s, en_d;
  logic       en_fall, win_act, win_done, win_abort, busy, reload;
  mode_t      mode_q;
  logic       wflag_q;

  lin_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({txd_pin, en_pin}),
    .dout(pins_s)
  );
  assign en_s  = pins_s[0];
  assign txd_s = pins_s[1];

  always_ff @(posedge clk) begin
    if (rst) en_d <= 1'b0;
    else en_d <= en_s;
  end
  assign en_fall = en_d && !en_s;

  assign win_abort = en_s || (mode_q != M_NORMAL);

  lin_sel_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk   (clk),
    .rst   (rst),
    .arm   (en_fall && (mode_q == M_NORMAL)),
    .abort (win_abort),
    .active(win_act),
    .done  (win_done)
  );

  assign reload = (mode_q == M_UNPOW) || (mode_q == M_SLEEP) || vreg_uv;

  lin_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .reload(reload),
    .busy  (busy)
  );

  lin_mode_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .vreg_uv  (vreg_uv),
    .en_s     (en_s),
    .txd_s    (txd_s),
    .wake     (wake_pulse),
    .hold     (busy),
    .win_done (win_done),
    .mode_q   (mode_q),
    .wflag_q  (wflag_q)
  );

  logic reg_on;
  assign reg_on = (mode_q != M_UNPOW) && (mode_q != M_SLEEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= M_FSAFE;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      vreg_en <= 1'b1;
      term_en <= 1'b1;
      rxd_low <= 1'b0;
      nres    <= 1'b0;
      sel_win <= 1'b0;
    end else begin
      mode_o  <= mode_q;
      tx_en   <= (mode_q == M_NORMAL) && !win_act;
      rx_en   <= (mode_q == M_NORMAL);
      vreg_en <= reg_on;
      term_en <= (mode_q == M_FSAFE) || (mode_q == M_NORMAL);
      rxd_low <= (mode_q == M_SLEEP) || ((mode_q == M_FSAFE) && wflag_q);
      nres    <= reg_on && !busy && !vreg_uv;
      sel_win <= win_act;
    end
  end
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       vreg_uv,
  input logic [2:0] mode_o,
  input logic       tx_en,
  input logic       rx_en,
  input logic       vreg_en,
  input logic       term_en,
  input logic       rxd_low,
  input logic       nres,
  input logic       sel_win
);
  AST_UNPOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> (!vreg_en && !nres && !term_en && !tx_en)); // R2
  AST_NRES_NEEDS_VREG: assert property (@(posedge clk) disable iff (rst)
    nres |-> vreg_en); // R3
  AST_TX_NEEDS_PATHS: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> (rx_en && term_en && vreg_en)); // R4
  AST_WIN_TX_OFF: assert property (@(posedge clk) disable iff (rst)
    sel_win |-> !tx_en); // R5
  AST_SLEEP_OUTS: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> (!vreg_en && rxd_low && !nres && !term_en)); // R6
  AST_WAKE_NO_TX: assert property (@(posedge clk) disable iff (rst)
    rxd_low |-> (!tx_en && !rx_en)); // R7
  AST_UV_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(vreg_uv) |-> !nres); // R8
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .supply_ok(supply_ok),
  .vreg_uv  (vreg_uv),
  .mode_o   (mode_o),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .vreg_en  (vreg_en),
  .term_en  (term_en),
  .rxd_low  (rxd_low),
  .nres     (nres),
  .sel_win  (sel_win)
);

// File: tb/lin_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lin_mode_ctrl_bench;
  localparam int RSTC = 64;
  localparam int WINC = 16;
  localparam int SETTLE = 200;

  localparam int UNP = 0, FS = 1, NRM = 2, SIL = 3, SLP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1, vreg_uv = 1'b0, en_pin = 1'b0, txd_pin = 1'b1, wake_pulse = 1'b0;
  logic [2:0] mode_o;
  logic tx_en, rx_en, vreg_en, term_en, rxd_low, nres, sel_win;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_mode_ctrl #(.RST_CYCLES(RSTC), .WIN_CYCLES(WINC)) u_lin_mode_ctrl (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .vreg_uv(vreg_uv),
    .en_pin(en_pin), .txd_pin(txd_pin), .wake_pulse(wake_pulse),
    .mode_o(mode_o), .tx_en(tx_en), .rx_en(rx_en), .vreg_en(vreg_en),
    .term_en(term_en), .rxd_low(rxd_low), .nres(nres), .sel_win(sel_win)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Model of one mode decision with settled inputs
  function automatic int step(input int m, input bit en, input bit txd, input bit wk,
                              input bit uv, inout bit wf);
    int nm = m;
    case (m)
      UNP: nm = FS;
      FS:  if (en && !uv) nm = NRM;
      NRM: if (uv) nm = FS; else if (!en) nm = txd ? SIL : SLP;
      SIL: if (uv) nm = FS; else if (wk) begin nm = FS; wf = 1'b1; end else if (en) nm = NRM;
      SLP: if (wk) begin nm = FS; wf = 1'b1; end else if (en) nm = FS;
      default: nm = FS;
    endcase
    if (nm == NRM) wf = 1'b0;
    return nm;
  endfunction

  task automatic go_mode(input int m);
    @(negedge clk);
    rst = 1'b1; supply_ok = 1'b1; vreg_uv = 1'b0; en_pin = 1'b0; txd_pin = 1'b1; wake_pulse = 1'b0;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(RSTC + 10);
    if (m != FS) begin
      en_pin = 1'b1;
      wait_cyc(10);
      if (m == SIL || m == SLP) begin
        txd_pin = (m == SIL);
        en_pin = 1'b0;
        wait_cyc(WINC + 10);
      end
    end
  endtask

  task automatic check_outs(input string req, input int m, input bit wf, input bit uv);
    bit von;
    von = (m != UNP) && (m != SLP);
    check(req, "mode", mode_o, m);
    check(req, "tx_en", tx_en, m == NRM);
    check(req, "rx_en", rx_en, m == NRM);
    check(req, "vreg_en", vreg_en, von);
    check(req, "term_en", term_en, (m == FS) || (m == NRM));
    check(req, "rxd_low", rxd_low, (m == SLP) || ((m == FS) && wf));
    check(req, "nres", nres, von && !uv);
  endtask

  initial begin
    wait (cyc > 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
    finish_up();
  end

  initial begin
    // R1: reset state
    wait_cyc(2);
    check("R1", "mode", mode_o, FS);
    check("R1", "vreg_en", vreg_en, 1);
    check("R1", "tx_en", tx_en, 0);
    check("R1", "nres", nres, 0);
    rst = 1'b0;
    wait_cyc(2);
    check("R1", "mode after release", mode_o, FS);

    // R2 / R3: supply loss, power-up delay blocks EN
    supply_ok = 1'b0;
    wait_cyc(5);
    check("R2", "mode", mode_o, UNP);
    check("R2", "vreg_en", vreg_en, 0);
    check("R2", "term_en", term_en, 0);
    supply_ok = 1'b1;
    en_pin = 1'b1;
    wait_cyc(RSTC / 2);
    check("R3", "mode held", mode_o, FS);
    check("R3", "nres held", nres, 0);
    wait_cyc(RSTC);
    check("R4", "mode", mode_o, NRM);
    check("R3", "nres released", nres, 1);

    // R5 / R6: TXD falls inside window -> sleep
    go_mode(NRM);
    txd_pin = 1'b1;
    en_pin = 1'b0;
    wait_cyc(4);
    txd_pin = 1'b0;
    wait_cyc(4);
    check("R5", "sel_win", sel_win, 1);
    check("R5", "tx_en in window", tx_en, 0);
    check("R5", "mode in window", mode_o, NRM);
    wait_cyc(WINC + 10);
    check("R6", "late txd fall sleep", mode_o, SLP);
    check("R6", "rxd_low", rxd_low, 1);

    // R6: TXD falls after window -> silent
    go_mode(NRM);
    txd_pin = 1'b1;
    en_pin = 1'b0;
    wait_cyc(WINC + 12);
    txd_pin = 1'b0;
    wait_cyc(10);
    check("R6", "silent after window", mode_o, SIL);
    check("R6", "vreg_en", vreg_en, 1);
    check("R6", "term_en", term_en, 0);

    // R5: EN returns within window -> stays normal
    go_mode(NRM);
    txd_pin = 1'b0;
    en_pin = 1'b0;
    wait_cyc(6);
    en_pin = 1'b1;
    wait_cyc(WINC + 20);
    check("R5", "cancel window", mode_o, NRM);
    check("R5", "tx_en restored", tx_en, 1);
    check("R5", "sel_win closed", sel_win, 0);

    // R2 / R3: supply loss in silent, return through delay
    go_mode(SIL);
    supply_ok = 1'b0;
    wait_cyc(4);
    check("R2", "silent to unpowered", mode_o, UNP);
    supply_ok = 1'b1;
    wait_cyc(4);
    check("R2", "back to fail-safe", mode_o, FS);
    check("R3", "nres low in delay", nres, 0);
    wait_cyc(RSTC + 4);
    check("R3", "nres after delay", nres, 1);

    // Sweep: every start mode times every input combination
    for (int sm = FS; sm <= SLP; sm++) begin
      for (int c = 0; c < 16; c++) begin
        bit en_v, txd_v, wk_v, uv_v, wf;
        int m;
        string req;
        en_v = c[0]; txd_v = c[1]; wk_v = c[2]; uv_v = c[3];
        go_mode(sm);
        en_pin = en_v; txd_pin = txd_v; vreg_uv = uv_v; wake_pulse = wk_v;
        wait_cyc(1);
        wake_pulse = 1'b0;
        wait_cyc(SETTLE);
        wf = 1'b0;
        m = step(sm, en_v, txd_v, wk_v, uv_v, wf);
        for (int k = 0; k < 4; k++) m = step(m, en_v, txd_v, 1'b0, uv_v, wf);
        if (uv_v && sm != SLP) req = "R8";
        else if (sm == FS) req = "R4";
        else if (sm == NRM) req = "R6";
        else if (wk_v) req = "R7";
        else req = "R9";
        check_outs(req, m, wf, uv_v && (m != SLP) && (m != UNP));
      end
    end
    finish_up();
  end
endmodule